// File: doc/BRIEF.md
# Multi-Rail Enable and Fault Supervisor

This block is the digital core of a multi-output supply controller. It turns three shutdown inputs into per-rail enable signals. It watches per-rail comparator flags and latches the whole controller off when a rail goes over voltage or, after its soft start, under voltage. An over-temperature flag shuts every rail down, and the controller restarts only after the die has cooled and the input supply has passed through undervoltage lockout. A power-good output reports when every enabled rail is settled and in its window. Every low pulse on that output lasts at least a minimum time.

The rails are packed into one vector, ordered as follows. First come `N_AON` always-on rails. Then come `N_MAIN` main rails, each gated by its own shutdown input. Last is one boost rail, which starts together with main rail 0. The analog comparators, the soft-start current sources and the regulators are outside the block. Each one reaches it as an asynchronous digital flag.

Top module: `rail_supervisor`

## Requirements
- R1: While `sd_all_i` is low, every bit of `en_rail_o` is 0.
- R2: While `sd_all_i` is high and nothing is tripped, the enable bits are set as follows. Bits 0..N_AON-1 (always-on) are 1. Bit N_AON+j follows `sd_main_i[j]`. The top bit (boost) follows `sd_main_i[0]`.
- R3: With `sd_all_i` high and every `sd_main_i` bit low (standby), only the always-on bits are 1, and `pgood_o` can still assert.
- R4: An overvoltage flag on an enabled rail clears every enable bit and raises `fault_off_o`.
- R5: An undervoltage flag on an enabled rail trips the same latch only while that rail's soft-start-done flag is high. An undervoltage flag with soft start pending, or on a disabled rail, leaves the enables unchanged.
- R6: `pgood_o` is low while any enabled rail has its in-window flag or soft-start-done flag low, and also while the block is off, in lockout or tripped. Otherwise it is high. Flags of disabled rails are ignored.
- R7: Every low period of `pgood_o` lasts at least PG_DIV*PG_TICKS+1 clock cycles. After a short disturbance it lasts exactly that long.
- R8: `ot_hot_i` clears all enables. The thermal latch clears only while `uvlo_i` is high and `ot_cool_i` is high together.
- R9: The over/undervoltage latch clears only while `uvlo_i` is high. Toggling the shutdown inputs leaves it set.
- R10: While `uvlo_i` is high, every enable bit is 0.
- R11: Every input passes through a two-stage synchroniser. A change driven between clock edges reaches `en_rail_o` on the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_all_i | input | 1 | Global enable, high = on |
| sd_main_i | input | N_MAIN | Per-main-rail enable, high = on |
| uvlo_i | input | 1 | Input supply below lockout threshold |
| ov_i | input | N_RAIL | Per-rail overvoltage flag |
| uv_i | input | N_RAIL | Per-rail undervoltage flag |
| win_i | input | N_RAIL | Per-rail in-window flag |
| ss_i | input | N_RAIL | Per-rail soft-start-done flag |
| ot_hot_i | input | 1 | Die above shutdown temperature |
| ot_cool_i | input | 1 | Die below recovery temperature |
| en_rail_o | output | N_RAIL | Per-rail enable |
| fault_off_o | output | 1 | Latched fault or thermal shutdown |
| pgood_o | output | 1 | Power good |

## Verification
The bench builds the block with two always-on rails and two main rails, which gives a five-bit rail vector. The power-good timer uses PG_DIV=3 and PG_TICKS=4, so the minimum low width is 13 cycles and can be measured exactly rather than bounded. With these sizes, every shutdown and lockout combination can be swept. The overvoltage and undervoltage trips can also be run on each rail in turn, each followed by a full lockout recovery.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;

  typedef enum logic [1:0] {
    SUP_OFF     = 2'd0,
    SUP_STANDBY = 2'd1,
    SUP_RUN     = 2'd2,
    SUP_TRIPPED = 2'd3
  } sup_mode_e;

  function automatic sup_mode_e sup_decode(input logic lockout, input logic global_on,
                                           input logic tripped, input logic any_main);
    if (lockout || !global_on) return SUP_OFF;
    if (tripped)               return SUP_TRIPPED;
    if (!any_main)             return SUP_STANDBY;
    return SUP_RUN;
  endfunction

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/rail_fault_latch.sv
module rail_fault_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lockout_i,
  input  logic         hot_i,
  input  logic         cool_i,
  input  logic [N-1:0] ov_i,
  input  logic [N-1:0] uv_i,
  input  logic [N-1:0] ss_i,
  input  logic [N-1:0] en_i,
  output logic         fault_o,
  output logic         therm_o
);
  logic fault_q, fault_n, therm_q, therm_n;
  logic ov_trip, uv_trip;

  always_comb begin
    ov_trip = |(ov_i & en_i);
    uv_trip = |(uv_i & ss_i & en_i);
    fault_n = fault_q;
    if (ov_trip || uv_trip) fault_n = 1'b1;
    else if (lockout_i)     fault_n = 1'b0;
    therm_n = therm_q;
    if (hot_i)                      therm_n = 1'b1;
    else if (lockout_i && cool_i)   therm_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      therm_q <= 1'b0;
    end else begin
      fault_q <= fault_n;
      therm_q <= therm_n;
    end
  end

  assign fault_o = fault_q;
  assign therm_o = therm_q;

  a_r4_ov_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ov_i & en_i)) |=> fault_q);
  a_r5_uv_waits_soft_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_q && (ov_i & en_i) == '0 && (uv_i & ss_i & en_i) == '0) |=> !fault_q);
  a_r9_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !lockout_i) |=> fault_q);
  a_r8_therm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_q && !(lockout_i && cool_i)) |=> therm_q);
endmodule

// File: rtl/rail_pg_timer.sv
module rail_pg_timer #(
  parameter int DIV   = 25,
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_good_i,
  output logic pgood_o
);
  localparam int PRE_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TICK_W  = $clog2(TICKS + 1);
  localparam int MIN_LOW = DIV * TICKS + 1;
  localparam int RUN_W   = $clog2(MIN_LOW + 1);

  logic              pg_q, pg_n;
  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [TICK_W-1:0] tick_q, tick_n;
  logic              tick_en;

  assign tick_en = (pre_q == PRE_W'(DIV - 1));

  always_comb begin
    pg_n   = pg_q;
    pre_n  = pre_q;
    tick_n = tick_q;
    if (pg_q) begin
      if (!raw_good_i) begin
        pg_n   = 1'b0;
        pre_n  = '0;
        tick_n = '0;
      end
    end else if (tick_q == TICK_W'(TICKS)) begin
      if (raw_good_i) pg_n = 1'b1;
    end else if (tick_en) begin
      pre_n  = '0;
      tick_n = tick_q + 1'b1;
    end else begin
      pre_n  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q   <= 1'b0;
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pg_q   <= pg_n;
      pre_q  <= pre_n;
      tick_q <= tick_n;
    end
  end

  assign pgood_o = pg_q;

  // checker: independent count of consecutive low cycles
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            low_run_q <= '0;
    else if (pg_q)                         low_run_q <= '0;
    else if (low_run_q != RUN_W'(MIN_LOW)) low_run_q <= low_run_q + 1'b1;
  end

  a_r7_min_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> (low_run_q >= RUN_W'(MIN_LOW)));
  a_r6_bad_drops_pgood: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_q && !raw_good_i) |=> !pg_q);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int N_AON    = 2,
  parameter int N_MAIN   = 2,
  parameter int PG_DIV   = 25,
  parameter int PG_TICKS = 50,
  localparam int N_RAIL  = N_AON + N_MAIN + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_all_i,
  input  logic [N_MAIN-1:0] sd_main_i,
  input  logic              uvlo_i,
  input  logic [N_RAIL-1:0] ov_i,
  input  logic [N_RAIL-1:0] uv_i,
  input  logic [N_RAIL-1:0] win_i,
  input  logic [N_RAIL-1:0] ss_i,
  input  logic              ot_hot_i,
  input  logic              ot_cool_i,
  output logic [N_RAIL-1:0] en_rail_o,
  output logic              fault_off_o,
  output logic              pgood_o
);
  localparam int BOOST_IDX = N_RAIL - 1;
  localparam int SYNC_W    = 4 + N_MAIN + 4 * N_RAIL;

  // synchronised inputs
  logic [SYNC_W-1:0] sync_d, sync_q;
  logic              sd_all_s, uvlo_s, hot_s, cool_s;
  logic [N_MAIN-1:0] sd_main_s;
  logic [N_RAIL-1:0] ov_s, uv_s, win_s, ss_s;

  assign sync_d = {sd_all_i, uvlo_i, ot_hot_i, ot_cool_i, sd_main_i, ov_i, uv_i, win_i, ss_i};

  rail_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {sd_all_s, uvlo_s, hot_s, cool_s, sd_main_s, ov_s, uv_s, win_s, ss_s} = sync_q;

  // fault and thermal latches
  logic              fault_q, therm_q;
  logic [N_RAIL-1:0] en_q, en_n;

  rail_fault_latch #(.N(N_RAIL)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .lockout_i (uvlo_s),
    .hot_i     (hot_s),
    .cool_i    (cool_s),
    .ov_i      (ov_s),
    .uv_i      (uv_s),
    .ss_i      (ss_s),
    .en_i      (en_q),
    .fault_o   (fault_q),
    .therm_o   (therm_q)
  );

  // rail request map
  logic [N_RAIL-1:0] req;
  sup_mode_e         mode;

  genvar gi;
  generate
    for (gi = 0; gi < N_AON; gi++) begin : g_aon
      assign req[gi] = 1'b1;
    end
    for (gi = 0; gi < N_MAIN; gi++) begin : g_main
      assign req[N_AON + gi] = sd_main_s[gi];
    end
  endgenerate
  assign req[BOOST_IDX] = sd_main_s[0];

  always_comb begin
    mode = sup_decode(uvlo_s, sd_all_s, fault_q | therm_q, |sd_main_s);
    if (mode == SUP_RUN || mode == SUP_STANDBY) en_n = req;
    else                                        en_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_n;
  end

  // power-good qualification
  logic raw_good;
  always_comb begin
    raw_good = (mode == SUP_RUN || mode == SUP_STANDBY) && (en_q == en_n)
               && (&(~en_q | (win_s & ss_s)));
  end

  rail_pg_timer #(.DIV(PG_DIV), .TICKS(PG_TICKS)) u_pg (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_good_i (raw_good),
    .pgood_o    (pgood_o)
  );

  assign en_rail_o   = en_q;
  assign fault_off_o = fault_q | therm_q;

  a_r1_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_all_s |=> (en_q == '0));
  a_r10_lockout_off: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_s |=> (en_q == '0));
  a_r4_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q || therm_q) |=> (en_q == '0));
  a_r6_trip_no_pgood: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q || therm_q) |=> !pgood_o);
endmodule

// File: tb/rail_supervisor_test.sv
module rail_supervisor_test;
  localparam int NR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sd_all = 1'b0;
  logic [1:0]    sd_main = 2'b00;
  logic          uvlo = 1'b0;
  logic [NR-1:0] ov = '0, uv = '0, win = '1, ss = '1;
  logic          hot = 1'b0, cool = 1'b1;
  logic [NR-1:0] en;
  logic          fault_off, pgood;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rail_supervisor #(.N_AON(2), .N_MAIN(2), .PG_DIV(3), .PG_TICKS(4)) uut (
    .clk(clk), .rst_n(rst_n), .sd_all_i(sd_all), .sd_main_i(sd_main), .uvlo_i(uvlo),
    .ov_i(ov), .uv_i(uv), .win_i(win), .ss_i(ss), .ot_hot_i(hot), .ot_cool_i(cool),
    .en_rail_o(en), .fault_off_o(fault_off), .pgood_o(pgood)
  );

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] exp_en(input logic a, input logic [1:0] m, input logic lo);
    if (lo || !a) return '0;
    return {m[0], m, 2'b11};
  endfunction

  task automatic lockout_cycle();
    uvlo = 1'b1;
    step(6);
    chk("R10 lockout clears enables", en, 0);
    uvlo = 1'b0;
    step(30);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("reset en", en, 0);
    chk("reset pgood", pgood, 0);
    chk("reset fault", fault_off, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R10 sweep
    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 4; m++)
        for (int u = 0; u < 2; u++) begin
          sd_all = a[0]; sd_main = m[1:0]; uvlo = u[0];
          step(30);
          chk($sformatf("R1 R2 R10 en a=%0d m=%0d u=%0d", a, m, u), en, exp_en(a[0], m[1:0], u[0]));
          chk($sformatf("R3 R6 pgood a=%0d m=%0d u=%0d", a, m, u), pgood, (a == 1 && u == 0) ? 1 : 0);
        end
    uvlo = 1'b0;

    // R11 latency
    sd_all = 1'b1; sd_main = 2'b11; step(30);
    sd_all = 1'b0;
    step(2);
    chk("R11 no change after two edges", en, 5'h1f);
    step(1);
    chk("R11 change on third edge", en, 0);
    sd_all = 1'b1; step(30);

    // R6 window / soft start, disabled rails ignored
    win[3] = 1'b0; step(30);
    chk("R6 out-of-window drops pgood", pgood, 0);
    win[3] = 1'b1; ss[2] = 1'b0; step(30);
    chk("R6 soft start pending drops pgood", pgood, 0);
    ss[2] = 1'b1; step(30);
    chk("R6 pgood returns", pgood, 1);
    sd_main = 2'b00; win[4:2] = 3'b000; step(30);
    chk("R3 R6 standby ignores disabled rails", pgood, 1);
    chk("R3 standby enables", en, 5'h03);
    uv[3] = 1'b1; ov[4] = 1'b1; step(10);
    chk("R5 flags on disabled rails ignored", fault_off, 0);
    uv[3] = 1'b0; ov[4] = 1'b0; win = '1; sd_main = 2'b11; step(30);

    // R7 min low width
    begin
      int low = 0;
      int guard = 0;
      win[0] = 1'b0; step(1); win[0] = 1'b1;
      while (pgood && guard < 20) begin step(1); guard++; end
      while (!pgood && low < 100) begin step(1); low++; end
      chk("R7 pgood low width", low, 13);
    end

    // R4 R9 overvoltage on each rail
    for (int i = 0; i < NR; i++) begin
      ov[i] = 1'b1; step(6); ov[i] = 1'b0;
      chk($sformatf("R4 ov rail %0d off", i), en, 0);
      chk($sformatf("R4 ov rail %0d fault", i), fault_off, 1);
      sd_all = 1'b0; step(6); sd_all = 1'b1; sd_main = 2'b00; step(6); sd_main = 2'b11; step(10);
      chk($sformatf("R9 rail %0d pins do not clear", i), fault_off, 1);
      chk($sformatf("R9 rail %0d stays off", i), en, 0);
      lockout_cycle();
      chk($sformatf("R9 rail %0d lockout clears", i), en, 5'h1f);
      chk($sformatf("R6 rail %0d pgood back", i), pgood, 1);
    end

    // R5 undervoltage gated by soft start
    for (int i = 0; i < NR; i++) begin
      ss[i] = 1'b0; uv[i] = 1'b1; step(10);
      chk($sformatf("R5 uv rail %0d before soft start", i), en, 5'h1f);
      chk($sformatf("R6 rail %0d ss pending pgood", i), pgood, 0);
      ss[i] = 1'b1; step(6);
      chk($sformatf("R5 uv rail %0d after soft start", i), fault_off, 1);
      uv[i] = 1'b0;
      lockout_cycle();
      chk($sformatf("R5 rail %0d recovered", i), en, 5'h1f);
    end

    // R8 thermal
    hot = 1'b1; cool = 1'b0; step(6);
    chk("R8 hot shuts down", en, 0);
    hot = 1'b0; lockout_cycle();
    chk("R8 lockout while warm keeps off", en, 0);
    cool = 1'b1; step(10);
    chk("R8 cooling alone keeps off", fault_off, 1);
    lockout_cycle();
    chk("R8 cool plus lockout restarts", en, 5'h1f);
    chk("R8 fault released", fault_off, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule